// File: doc/BRIEF.md
# Row-Buffered Bit Memory

This block models a small dynamic memory core: 256 bits held as 16 rows of 16 bits. The array is never touched one cell at a time. Every transfer between the array and the outside world moves a whole row into or out of one of four row buffers at the array edge. Single bits are picked out of, or changed inside, a buffer.

A command port exposes the internal steps as separate commands. One command fetches a row into a buffer. One reads a bit of a buffer. One changes a bit of a buffer. One stores a buffer back into the row it came from. Fetch and store take a fixed number of cycles. While one is in flight, its buffer is marked busy and refuses new commands, but the other buffers stay free, so work on different buffers overlaps. A second, simpler port takes a flat bit address and performs the whole fetch, select or modify, and store sequence on buffer 0 by itself. It reports completion with a one-cycle pulse.

Top module: `rowbuf_mem`

## Requirements
- R1: After reset every buffer is invalid and idle, the array holds all zeros, `cmd_ready` and `bit_ready` are 1, and `rd_valid`, `err` and `bit_done` are 0.
- R2: The array has 16 rows of 16 bits. Column c of a row is bit c of that row's 16-bit word, and a flat bit address carries the row in bits 7:4 and the column in bits 3:0.
- R3: A fetch (opcode 1) copies the addressed row into the chosen buffer and keeps that buffer busy for 2 cycles. `cmd_ready` for that buffer is 0 in the two cycles after acceptance and 1 in the third. The buffer then reads as valid.
- R4: A bit read (opcode 2) on a valid, idle buffer gives `rd_valid`=1 and `rd_data` equal to the selected column of the buffer in the cycle after acceptance.
- R5: A bit change (opcode 3) alters only the chosen bit of the buffer. The array row is unchanged until that buffer is stored back.
- R6: A store (opcode 4) keeps the buffer busy for 2 cycles and then writes the whole buffer into the row it was fetched from.
- R7: A bit read, bit change or store on a buffer that holds no row is ignored, and `err` pulses for one cycle in the cycle after acceptance, with `rd_valid` 0.
- R8: Commands to different buffers overlap. While one buffer is busy fetching, a fetch into another buffer is accepted at once.
- R9: When two buffers hold the same row and both are stored, the store issued later determines the row contents.
- R10: A flat bit read (`bit_we`=0) returns the addressed array bit on `bit_rdata` while `bit_done` pulses for one cycle.
- R11: A flat bit write (`bit_we`=1) fetches the row into buffer 0, changes the addressed bit, stores the row, and pulses `bit_done` once the store has finished. The other bits of that row keep their values.
- R12: Opcodes 0, 5, 6 and 7 do nothing. They raise neither `rd_valid` nor `err` and leave buffers and array unchanged.
- R13: From the cycle a flat request is taken until its `bit_done`, `cmd_ready` and `bit_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode: 0 none, 1 fetch, 2 bit read, 3 bit change, 4 store |
| cmd_buf | input | 2 | Target buffer index |
| cmd_row | input | 4 | Row for a fetch |
| cmd_col | input | 4 | Column for bit read or change |
| cmd_wdata | input | 1 | New bit value for a bit change |
| cmd_ready | output | 1 | Command is taken this cycle if valid |
| rd_valid | output | 1 | Bit read result present |
| rd_data | output | 1 | Bit read result |
| err | output | 1 | Previous command targeted an empty buffer |
| bit_req | input | 1 | Flat bit request, taken when `bit_ready` is 1 |
| bit_we | input | 1 | 1 write, 0 read |
| bit_addr | input | 8 | Flat bit address, row in 7:4, column in 3:0 |
| bit_wdata | input | 1 | Bit to write |
| bit_ready | output | 1 | Flat port idle |
| bit_done | output | 1 | One-cycle completion pulse |
| bit_rdata | output | 1 | Read bit, valid with `bit_done` on a read |

## Verification
A buffer left with a stale row tag or a wrong valid flag shows up at once: a store lands in the wrong row, or a bit read raises `err` in the cycle after the command. A fetch that copies the wrong row, or a store that drops a bit, shows only when that row is read again. The bench therefore reads back every row through a fresh fetch, first into a different buffer and finally over the whole array. A busy count that is off by one changes the cycle in which `cmd_ready` returns. It also breaks the order of two stores to one row, which a later read of that row exposes.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_RDBIT = 3'd2,
    OP_WRBIT = 3'd3,
    OP_WBACK = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    CV_IDLE,
    CV_LOAD,
    CV_SEL,
    CV_RDW,
    CV_WBK,
    CV_WWB
  } conv_st_e;

endpackage

// File: rtl/rowbuf_array.sv
module rowbuf_array #(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] rd_row,
  output logic [COLS-1:0]  rd_data,
  input  logic             we,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COLS-1:0]  wr_data
);

  logic [COLS-1:0] mem [ROWS];

  assign rd_data = mem[rd_row];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (we) begin
      mem[wr_row] <= wr_data;
    end
  end

endmodule

// File: rtl/rowbuf_slot.sv
module rowbuf_slot #(
  parameter int COLS   = 16,
  parameter int ROW_W  = 4,
  parameter int OP_LAT = 2,
  localparam int COL_W = $clog2(COLS),
  localparam int CNT_W = $clog2(OP_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_load,
  input  logic             iss_wback,
  input  logic             iss_wbit,
  input  logic [COL_W-1:0] wbit_col,
  input  logic             wbit_val,
  input  logic [ROW_W-1:0] load_row,
  input  logic [COLS-1:0]  arr_rdata,
  output logic             busy,
  output logic             valid,
  output logic [ROW_W-1:0] row,
  output logic [COLS-1:0]  data,
  output logic             ld_fire,
  output logic             wb_fire
);

  logic [CNT_W-1:0] cnt;
  logic             pend_wb;
  logic             last;

  function automatic logic [COLS-1:0] put_bit(input logic [COLS-1:0] w,
                                               input logic [COL_W-1:0] c,
                                               input logic v);
    logic [COLS-1:0] r;
    r    = w;
    r[c] = v;
    return r;
  endfunction

  assign busy    = (cnt != '0);
  assign last    = (cnt == CNT_W'(1));
  assign ld_fire = last && !pend_wb;
  assign wb_fire = last && pend_wb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pend_wb <= 1'b0;
      valid   <= 1'b0;
      row     <= '0;
      data    <= '0;
    end else begin
      if (iss_load) begin
        cnt     <= CNT_W'(OP_LAT);
        pend_wb <= 1'b0;
        row     <= load_row;
        valid   <= 1'b0;
      end else if (iss_wback) begin
        cnt     <= CNT_W'(OP_LAT);
        pend_wb <= 1'b1;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
      end
      if (ld_fire) begin
        data  <= arr_rdata;
        valid <= 1'b1;
      end else if (iss_wbit) begin
        data <= put_bit(data, wbit_col, wbit_val);
      end
    end
  end

endmodule

// File: rtl/rowbuf_seq.sv
module rowbuf_seq
  import rowbuf_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_req,
  input  logic              bit_we,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_wdata,
  input  logic              buf_busy,
  output logic              conv_own,
  output logic              bit_done,
  output logic              cv_valid,
  output op_e               cv_op,
  output logic [ROW_W-1:0]  cv_row,
  output logic [COL_W-1:0]  cv_col,
  output logic              cv_wdata
);

  conv_st_e         st;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             we_q;
  logic             wd_q;

  function automatic logic [ROW_W-1:0] addr_row(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: ROW_W];
  endfunction

  function automatic logic [COL_W-1:0] addr_col(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= CV_IDLE;
      row_q <= '0;
      col_q <= '0;
      we_q  <= 1'b0;
      wd_q  <= 1'b0;
    end else begin
      case (st)
        CV_IDLE: if (bit_req) begin
          row_q <= addr_row(bit_addr);
          col_q <= addr_col(bit_addr);
          we_q  <= bit_we;
          wd_q  <= bit_wdata;
          st    <= CV_LOAD;
        end
        CV_LOAD: if (!buf_busy) st <= CV_SEL;
        CV_SEL:  if (!buf_busy) st <= we_q ? CV_WBK : CV_RDW;
        CV_RDW:  st <= CV_IDLE;
        CV_WBK:  if (!buf_busy) st <= CV_WWB;
        CV_WWB:  if (!buf_busy) st <= CV_IDLE;
        default: st <= CV_IDLE;
      endcase
    end
  end

  always_comb begin
    cv_valid = 1'b0;
    cv_op    = OP_NOP;
    case (st)
      CV_LOAD: begin cv_valid = !buf_busy; cv_op = OP_LOAD; end
      CV_SEL:  begin cv_valid = !buf_busy; cv_op = we_q ? OP_WRBIT : OP_RDBIT; end
      CV_WBK:  begin cv_valid = !buf_busy; cv_op = OP_WBACK; end
      default: ;
    endcase
  end

  assign cv_row   = row_q;
  assign cv_col   = col_q;
  assign cv_wdata = wd_q;
  assign conv_own = (st != CV_IDLE);
  assign bit_done = (st == CV_RDW) || ((st == CV_WWB) && !buf_busy);

endmodule

// File: rtl/rowbuf_mem.sv
module rowbuf_mem
  import rowbuf_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int NBUF   = 4,
  parameter int OP_LAT = 2,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int BUF_W  = $clog2(NBUF),
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BUF_W-1:0]  cmd_buf,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              cmd_wdata,
  output logic              cmd_ready,
  output logic              rd_valid,
  output logic              rd_data,
  output logic              err,
  input  logic              bit_req,
  input  logic              bit_we,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_wdata,
  output logic              bit_ready,
  output logic              bit_done,
  output logic              bit_rdata
);

  // Per-buffer state and internal events, named for the checker
  logic [NBUF-1:0]  slot_busy;
  logic [NBUF-1:0]  slot_valid;
  logic [NBUF-1:0]  ld_fire;
  logic [NBUF-1:0]  wb_fire;
  logic [NBUF-1:0]  iss_load;
  logic [NBUF-1:0]  iss_wback;
  logic [NBUF-1:0]  iss_wbit;
  logic [ROW_W-1:0] slot_row  [NBUF];
  logic [COLS-1:0]  slot_data [NBUF];

  // Flat-port sequencer
  logic             own;
  logic             cv_valid;
  op_e              cv_op;
  logic [ROW_W-1:0] cv_row;
  logic [COL_W-1:0] cv_col;
  logic             cv_wdata;

  // Merged command
  logic             ext_go;
  logic             int_acc;
  op_e              int_op;
  logic [BUF_W-1:0] int_buf;
  logic [ROW_W-1:0] int_row;
  logic [COL_W-1:0] int_col;
  logic             int_wdata;
  logic             needs_row;
  logic             bad_req;
  logic             good_rd;

  // Array ports
  logic [ROW_W-1:0] arr_rd_row;
  logic [COLS-1:0]  arr_rd_data;
  logic             arr_we;
  logic [ROW_W-1:0] arr_wr_row;
  logic [COLS-1:0]  arr_wr_data;

  logic rd_valid_q, rd_data_q, err_q;

  rowbuf_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_req  (bit_req),
    .bit_we   (bit_we),
    .bit_addr (bit_addr),
    .bit_wdata(bit_wdata),
    .buf_busy (slot_busy[0]),
    .conv_own (own),
    .bit_done (bit_done),
    .cv_valid (cv_valid),
    .cv_op    (cv_op),
    .cv_row   (cv_row),
    .cv_col   (cv_col),
    .cv_wdata (cv_wdata)
  );

  // The flat port owns the command path from the cycle its request arrives
  assign cmd_ready = !own && !bit_req && !slot_busy[cmd_buf];
  assign bit_ready = !own;
  assign ext_go    = cmd_valid && cmd_ready;

  always_comb begin
    if (own) begin
      int_acc   = cv_valid;
      int_op    = cv_op;
      int_buf   = '0;
      int_row   = cv_row;
      int_col   = cv_col;
      int_wdata = cv_wdata;
    end else begin
      int_acc   = ext_go;
      int_op    = op_e'(cmd_op);
      int_buf   = cmd_buf;
      int_row   = cmd_row;
      int_col   = cmd_col;
      int_wdata = cmd_wdata;
    end
  end

  assign needs_row = (int_op == OP_RDBIT) || (int_op == OP_WRBIT) || (int_op == OP_WBACK);
  assign bad_req   = int_acc && needs_row && !slot_valid[int_buf];
  assign good_rd   = int_acc && (int_op == OP_RDBIT) && slot_valid[int_buf];

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    logic hit;
    assign hit          = int_acc && (int_buf == BUF_W'(i));
    assign iss_load[i]  = hit && (int_op == OP_LOAD);
    assign iss_wbit[i]  = hit && (int_op == OP_WRBIT) && slot_valid[i];
    assign iss_wback[i] = hit && (int_op == OP_WBACK) && slot_valid[i];

    rowbuf_slot #(.COLS(COLS), .ROW_W(ROW_W), .OP_LAT(OP_LAT)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .iss_load (iss_load[i]),
      .iss_wback(iss_wback[i]),
      .iss_wbit (iss_wbit[i]),
      .wbit_col (int_col),
      .wbit_val (int_wdata),
      .load_row (int_row),
      .arr_rdata(arr_rd_data),
      .busy     (slot_busy[i]),
      .valid    (slot_valid[i]),
      .row      (slot_row[i]),
      .data     (slot_data[i]),
      .ld_fire  (ld_fire[i]),
      .wb_fire  (wb_fire[i])
    );
  end

  // At most one buffer completes a fetch and one a store in any cycle
  always_comb begin
    arr_rd_row  = '0;
    arr_wr_row  = '0;
    arr_wr_data = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (ld_fire[i]) arr_rd_row = arr_rd_row | slot_row[i];
      if (wb_fire[i]) begin
        arr_wr_row  = arr_wr_row | slot_row[i];
        arr_wr_data = arr_wr_data | slot_data[i];
      end
    end
  end
  assign arr_we = |wb_fire;

  rowbuf_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_row (arr_rd_row),
    .rd_data(arr_rd_data),
    .we     (arr_we),
    .wr_row (arr_wr_row),
    .wr_data(arr_wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      rd_valid_q <= good_rd;
      err_q      <= bad_req;
      if (good_rd) rd_data_q <= slot_data[int_buf][int_col];
    end
  end

  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign err       = err_q;
  assign bit_rdata = rd_data_q;

endmodule

// File: rtl/rowbuf_chk.sv
module rowbuf_chk #(
  parameter int NBUF = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NBUF-1:0] ld_fire,
  input logic [NBUF-1:0] wb_fire,
  input logic [NBUF-1:0] slot_valid,
  input logic            rd_valid,
  input logic            err,
  input logic            bad_req,
  input logic            bit_done,
  input logic            cmd_ready,
  input logic            own
);

  assert_one_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_fire));

  assert_one_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_fire));

  assert_fetch_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ld_fire) |=> ((slot_valid & $past(ld_fire)) == $past(ld_fire)));

  assert_err_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rd_valid);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(bad_req));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done);

  assert_port_owned_R13: assert property (@(posedge clk) disable iff (!rst_n)
    own |-> !cmd_ready);

endmodule

bind rowbuf_mem rowbuf_chk #(.NBUF(NBUF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_fire   (ld_fire),
  .wb_fire   (wb_fire),
  .slot_valid(slot_valid),
  .rd_valid  (rd_valid),
  .err       (err),
  .bad_req   (bad_req),
  .bit_done  (bit_done),
  .cmd_ready (cmd_ready),
  .own       (own)
);

// File: tb/test_rowbuf_mem.sv
module test_rowbuf_mem;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_buf = '0;
  logic [3:0] cmd_row = '0;
  logic [3:0] cmd_col = '0;
  logic       cmd_wdata = 1'b0;
  logic       cmd_ready, rd_valid, rd_data, err;
  logic       bit_req = 1'b0;
  logic       bit_we = 1'b0;
  logic [7:0] bit_addr = '0;
  logic       bit_wdata = 1'b0;
  logic       bit_ready, bit_done, bit_rdata;

  int checks = 0;
  int errors = 0;
  logic [15:0] ref_rows [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  rowbuf_mem i_rowbuf_mem (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_buf(cmd_buf),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata),
    .cmd_ready(cmd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .err(err),
    .bit_req(bit_req), .bit_we(bit_we), .bit_addr(bit_addr), .bit_wdata(bit_wdata),
    .bit_ready(bit_ready), .bit_done(bit_done), .bit_rdata(bit_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic ref_bit(input int r, input int c);
    return ref_rows[r][c];
  endfunction

  // Drive one command and return just after the edge that takes it
  task automatic issue(input logic [2:0] op, input int b, input int r,
                       input int c, input logic wd);
    @(negedge clk);
    cmd_op = op; cmd_buf = 2'(b); cmd_row = 4'(r); cmd_col = 4'(c);
    cmd_wdata = wd; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic rd_direct(input int b, input int c, output logic v,
                           output logic d, output logic e);
    issue(3'd2, b, 0, c, 1'b0);
    @(negedge clk);
    v = rd_valid; d = rd_data; e = err;
  endtask

  task automatic flat(input logic we, input int r, input int c,
                      input logic wd, output logic rdata);
    int n;
    @(negedge clk);
    while (!bit_ready) @(negedge clk);
    bit_we = we; bit_addr = {4'(r), 4'(c)}; bit_wdata = wd; bit_req = 1'b1;
    @(posedge clk);
    #1 bit_req = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bit_done && n < 100);
    if (n >= 100) chk("R10 done timeout", 0, 1);
    rdata = bit_rdata;
    if (we) ref_rows[r][c] = wd;
  endtask

  task automatic t_reset;
    logic d;
    @(negedge clk);
    chk("R1 cmd_ready", int'(cmd_ready), 1);
    chk("R1 bit_ready", int'(bit_ready), 1);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 bit_done", int'(bit_done), 0);
    flat(1'b0, 3, 5, 1'b0, d);
    chk("R1 array zero", int'(d), 0);
  endtask

  task automatic t_invalid;
    logic v, d, e;
    rd_direct(2, 5, v, d, e);
    chk("R7 read empty err", int'(e), 1);
    chk("R7 read empty no rd_valid", int'(v), 0);
    @(negedge clk);
    chk("R7 err one pulse", int'(err), 0);
    issue(3'd4, 3, 0, 0, 1'b0);
    @(negedge clk);
    chk("R7 store empty err", int'(err), 1);
    issue(3'd3, 2, 0, 4, 1'b1);
    @(negedge clk);
    chk("R7 change empty err", int'(err), 1);
    issue(3'd1, 2, 0, 0, 1'b0);
    rd_direct(2, 4, v, d, e);
    chk("R7 change ignored", int'(d), 0);
    chk("R7 valid after fetch", int'(v), 1);
  endtask

  task automatic t_flat_write;
    logic d;
    for (int k = 0; k < 40; k++) begin
      int a;
      a = (k * 37 + 11) % 256;
      flat(1'b1, a / 16, a % 16, logic'((k % 3) != 0), d);
    end
    for (int k = 0; k < 40; k++) begin
      int a;
      a = (k * 37 + 11) % 256;
      flat(1'b0, a / 16, a % 16, 1'b0, d);
      chk("R11 flat write readback", int'(d), int'(ref_bit(a / 16, a % 16)));
      flat(1'b0, a / 16, (a + 1) % 16, 1'b0, d);
      chk("R11 row neighbour kept", int'(d), int'(ref_bit(a / 16, (a + 1) % 16)));
    end
  endtask

  task automatic t_fetch_latency;
    logic v, d, e;
    issue(3'd1, 1, 3, 0, 1'b0);
    cmd_buf = 2'd1;
    @(negedge clk);
    chk("R3 busy cycle 1", int'(cmd_ready), 0);
    cmd_buf = 2'd2;
    #1 chk("R8 other buffer free", int'(cmd_ready), 1);
    cmd_buf = 2'd1;
    @(negedge clk);
    chk("R3 busy cycle 2", int'(cmd_ready), 0);
    @(negedge clk);
    chk("R3 free cycle 3", int'(cmd_ready), 1);
    for (int c = 0; c < 16; c++) begin
      rd_direct(1, c, v, d, e);
      chk("R4 rd_valid", int'(v), 1);
      chk("R2 R4 bit of row 3", int'(d), int'(ref_bit(3, c)));
    end
  endtask

  task automatic t_modify;
    logic v, d, e, nv;
    nv = ~ref_bit(3, 9);
    issue(3'd3, 1, 0, 9, nv);
    rd_direct(1, 9, v, d, e);
    chk("R5 buffer bit changed", int'(d), int'(nv));
    issue(3'd1, 2, 3, 0, 1'b0);
    rd_direct(2, 9, v, d, e);
    chk("R5 array untouched", int'(d), int'(ref_bit(3, 9)));
    issue(3'd4, 1, 0, 0, 1'b0);
    ref_rows[3][9] = nv;
    issue(3'd1, 3, 3, 0, 1'b0);
    for (int c = 0; c < 16; c++) begin
      rd_direct(3, c, v, d, e);
      chk("R6 stored row", int'(d), int'(ref_bit(3, c)));
    end
  endtask

  task automatic t_overlap;
    logic v, d, e;
    issue(3'd1, 0, 5, 0, 1'b0);
    cmd_buf = 2'd1;
    @(negedge clk);
    chk("R8 fetch accepted while other busy", int'(cmd_ready), 1);
    issue(3'd1, 1, 6, 0, 1'b0);
    rd_direct(0, 12, v, d, e);
    chk("R8 buffer 0 row 5", int'(d), int'(ref_bit(5, 12)));
    rd_direct(1, 7, v, d, e);
    chk("R8 buffer 1 row 6", int'(d), int'(ref_bit(6, 7)));
  endtask

  task automatic t_last_wins;
    logic d, b0, b1;
    b0 = ~ref_bit(7, 0);
    b1 = ~ref_bit(7, 1);
    issue(3'd1, 0, 7, 0, 1'b0);
    issue(3'd1, 1, 7, 0, 1'b0);
    issue(3'd3, 0, 0, 0, b0);
    issue(3'd3, 1, 0, 1, b1);
    issue(3'd4, 1, 0, 0, 1'b0);
    issue(3'd4, 0, 0, 0, 1'b0);
    ref_rows[7][0] = b0;
    flat(1'b0, 7, 0, 1'b0, d);
    chk("R9 later store bit 0", int'(d), int'(b0));
    flat(1'b0, 7, 1, 1'b0, d);
    chk("R9 earlier store lost bit 1", int'(d), int'(ref_bit(7, 1)));
  endtask

  task automatic t_nops;
    logic v, d, e;
    issue(3'd1, 1, 4, 0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      logic [2:0] op;
      op = (k == 0) ? 3'd0 : 3'(k + 4);
      issue(op, 1, 2, k + 2, ~ref_bit(4, k + 2));
      @(negedge clk);
      chk("R12 no rd_valid", int'(rd_valid), 0);
      chk("R12 no err", int'(err), 0);
    end
    for (int c = 0; c < 16; c++) begin
      rd_direct(1, c, v, d, e);
      chk("R12 buffer unchanged", int'(d), int'(ref_bit(4, c)));
    end
  endtask

  task automatic t_owned;
    int n;
    @(negedge clk);
    while (!bit_ready) @(negedge clk);
    bit_we = 1'b1; bit_addr = 8'h2c; bit_wdata = 1'b1; bit_req = 1'b1;
    cmd_buf = 2'd3;
    #1 chk("R13 blocked on request cycle", int'(cmd_ready), 0);
    @(posedge clk);
    #1 bit_req = 1'b0;
    @(negedge clk);
    chk("R13 cmd_ready low", int'(cmd_ready), 0);
    chk("R13 bit_ready low", int'(bit_ready), 0);
    n = 0;
    while (!bit_done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R11 write done", int'(bit_done), 1);
    ref_rows[2][12] = 1'b1;
    @(negedge clk);
    chk("R13 released", int'(cmd_ready), 1);
  endtask

  task automatic t_sweep;
    logic d;
    for (int a = 0; a < 256; a++) begin
      flat(1'b0, a / 16, a % 16, 1'b0, d);
      chk("R2 R10 sweep", int'(d), int'(ref_bit(a / 16, a % 16)));
    end
  endtask

  initial begin
    for (int r = 0; r < 16; r++) ref_rows[r] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_invalid();
    t_flat_write();
    t_fetch_latency();
    t_modify();
    t_overlap();
    t_last_wins();
    t_nops();
    t_owned();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule